// File: doc/BRIEF.md
# Three-Wire Time Serial Transmitter

This block sends short control words to analog slave chips over a three-wire time serial link. The link clock is the continuous system clock, and every slave sees it directly. The block decides on its falling edges what the data, strobe and enable wires carry, so each value is settled half a period before the rising edge at which a slave may look at it.

A transfer is requested with a word and a mode on a ready/valid port. In strobe mode the whole word goes out MSB first, one bit per clock. A one-clock strobe pulse then tells the slave to latch the word. In enable mode only the low seven bits are sent, under an active-low enable. That kind of slave divides the clock by two internally, starting from the enable. The block rebuilds that hidden phase so that each bit is centred on one of the slave's half-rate rising edges. The enable is then dropped within a single falling-edge window, so the slave does not start a further transfer. A one-cycle `done` pulse closes each transfer.

Top module: `tsp_tx_top`

## Requirements
- R1: After reset `tsp_en_n` is 1, `tsp_strobe` and `tsp_data` are 0, `req_ready` is 1 and `done` is 0.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the transfer ends. A request offered while `req_ready` is 0 is ignored and does not alter the transfer in progress.
- R3: In strobe mode (`req_mode` = 0), falling edge k after the accepting rising edge (k = 0 is the first) drives `req_word[DATA_W-1-k]` onto `tsp_data` for k = 0..DATA_W-1. The bits go MSB first, each held until the next falling edge.
- R4: In strobe mode `tsp_strobe` is 1 only from falling edge DATA_W to falling edge DATA_W+1, with `tsp_data` at 0 meanwhile.
- R5: In enable mode (`req_mode` = 1), `tsp_en_n` goes low at falling edge 0 and returns high at falling edge 14. This is one period after the last half-rate sampling edge and before the next rising edge.
- R6: In enable mode, bit j of `req_word[6:0]` (j = 0 is bit 6) is driven from falling edge 2j to falling edge 2j+2. The slave's half-rate clock rises at odd falling edges and therefore sees the seven bits in order. Bits above 6 are not sent.
- R7: `tsp_en_n` stays 1 during a strobe-mode transfer, and `tsp_strobe` stays 0 during an enable-mode transfer.
- R8: `done` is 1 for exactly one cycle, starting at rising edge L after acceptance, where L = DATA_W+1 in strobe mode and L = 14 in enable mode. `req_ready` returns to 1 at rising edge L+1.
- R9: `tsp_data` is 0 whenever no bit is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous link clock, also the slaves' serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mode | input | 1 | 0 = strobe mode, 1 = enable mode |
| req_word | input | DATA_W | Word to send |
| tsp_data | output | 1 | Serial data, changes on falling edges |
| tsp_strobe | output | 1 | Latch strobe for strobe-mode slaves |
| tsp_en_n | output | 1 | Active-low enable for enable-mode slaves |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
All timing is counted from the rising edge that accepts a request. The three link wires answer at falling edge k, half a cycle later. `done` and `req_ready` answer at rising edge k. The bench samples each wire a few nanoseconds after the edge that launched it, for every k up to L+1. Its expected value comes from the bench's own per-cycle formulas. A slave model also gathers the bits at the edges where the real slave samples them (rising edges in strobe mode, odd falling edges in enable mode) and compares the assembled word.

// File: rtl/tsp_pkg.sv
`timescale 1ns/1ps
package tsp_pkg;

  typedef enum logic {
    MODE_STROBE = 1'b0,
    MODE_ENABLE = 1'b1
  } tsp_mode_e;

  // cycle index (after accept) of the closing, done-carrying cycle
  function automatic int unsigned last_cycle(tsp_mode_e m, int unsigned dw, int unsigned eb);
    return (m == MODE_ENABLE) ? 2 * eb : dw + 1;
  endfunction

  // enable held low while the half-rate slave clock has bits left
  function automatic logic en_active(int unsigned c, int unsigned eb);
    return c < 2 * eb;
  endfunction

  // each enable-mode bit spans two cycles, MSB of the eb-bit field first
  function automatic int unsigned en_bit_idx(int unsigned c, int unsigned eb);
    return eb - 1 - (c >> 1);
  endfunction

  // strobe-mode bit index, MSB first, one per cycle
  function automatic int unsigned stb_bit_idx(int unsigned c, int unsigned dw);
    return dw - 1 - c;
  endfunction

endpackage

// File: rtl/tsp_sequencer.sv
`timescale 1ns/1ps
module tsp_sequencer #(
  parameter int DATA_W  = 16,
  parameter int EN_BITS = 7,
  parameter int CNT_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_mode,
  input  logic [DATA_W-1:0]   req_word,
  output logic                req_ready,
  output logic                busy,
  output logic [CNT_W-1:0]    cnt,
  output tsp_pkg::tsp_mode_e  mode,
  output logic [DATA_W-1:0]   word,
  output logic                done
);
  import tsp_pkg::*;

  logic             accept;
  logic [CNT_W-1:0] last_c;

  assign accept    = req_valid && !busy;
  assign req_ready = !busy;
  assign last_c    = CNT_W'(last_cycle(mode, DATA_W, EN_BITS));
  assign done      = busy && (cnt == last_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      mode <= MODE_STROBE;
      word <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
      mode <= tsp_mode_e'(req_mode);
      word <= req_word;
    end else if (busy) begin
      if (cnt == last_c) busy <= 1'b0;
      else               cnt  <= cnt + CNT_W'(1);
    end
  end

  // R2: a request seen mid-transfer leaves the captured job alone
  a_r2_busy_ignores_req: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && !done) |=> (busy && $stable(word) && $stable(mode)));

  // R8: done is a single-cycle pulse, followed by readiness
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

endmodule

// File: rtl/tsp_decode.sv
`timescale 1ns/1ps
module tsp_decode #(
  parameter int DATA_W  = 16,
  parameter int EN_BITS = 7,
  parameter int CNT_W   = 5
) (
  input  logic                busy,
  input  logic [CNT_W-1:0]    cnt,
  input  tsp_pkg::tsp_mode_e  mode,
  input  logic [DATA_W-1:0]   word,
  output logic                nxt_data,
  output logic                nxt_stb,
  output logic                nxt_en_n
);
  import tsp_pkg::*;

  int unsigned       c;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    c        = 32'(cnt);
    shifted  = '0;
    nxt_data = 1'b0;
    nxt_stb  = 1'b0;
    nxt_en_n = 1'b1;
    if (busy) begin
      if (mode == MODE_ENABLE) begin
        if (en_active(c, EN_BITS)) begin
          nxt_en_n = 1'b0;
          shifted  = word >> en_bit_idx(c, EN_BITS);
          nxt_data = shifted[0];
        end
      end else begin
        if (c < DATA_W) begin
          shifted  = word >> stb_bit_idx(c, DATA_W);
          nxt_data = shifted[0];
        end else if (c == DATA_W) begin
          nxt_stb = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tsp_launch.sv
`timescale 1ns/1ps
module tsp_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic nxt_data,
  input  logic nxt_stb,
  input  logic nxt_en_n,
  output logic data_q,
  output logic stb_q,
  output logic en_n_q
);

  // falling-edge launch: values settle half a period before slaves look
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      stb_q  <= 1'b0;
      en_n_q <= 1'b1;
    end else begin
      data_q <= nxt_data;
      stb_q  <= nxt_stb;
      en_n_q <= nxt_en_n;
    end
  end

  // R4: strobe never lasts beyond one period
  a_r4_strobe_one_period: assert property (@(negedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

  // R7: the two framing wires are never active together
  a_r7_frame_exclusive: assert property (@(negedge clk) disable iff (!rst_n)
    !(stb_q && !en_n_q));

endmodule

// File: rtl/tsp_tx_top.sv
`timescale 1ns/1ps
module tsp_tx_top #(
  parameter int DATA_W  = 16,
  parameter int EN_BITS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_mode,
  input  logic [DATA_W-1:0] req_word,
  output logic              tsp_data,
  output logic              tsp_strobe,
  output logic              tsp_en_n,
  output logic              done
);
  localparam int LAST_MAX = (2 * EN_BITS > DATA_W + 1) ? 2 * EN_BITS : DATA_W + 1;
  localparam int CNT_W    = $clog2(LAST_MAX + 1);

  logic               busy;
  logic [CNT_W-1:0]   cnt;
  tsp_pkg::tsp_mode_e mode;
  logic [DATA_W-1:0]  word;
  logic               nxt_data, nxt_stb, nxt_en_n;

  tsp_sequencer #(.DATA_W(DATA_W), .EN_BITS(EN_BITS), .CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_word(req_word), .req_ready(req_ready), .busy(busy), .cnt(cnt),
    .mode(mode), .word(word), .done(done)
  );

  tsp_decode #(.DATA_W(DATA_W), .EN_BITS(EN_BITS), .CNT_W(CNT_W)) dec_i (
    .busy(busy), .cnt(cnt), .mode(mode), .word(word),
    .nxt_data(nxt_data), .nxt_stb(nxt_stb), .nxt_en_n(nxt_en_n)
  );

  tsp_launch launch_i (
    .clk(clk), .rst_n(rst_n), .nxt_data(nxt_data), .nxt_stb(nxt_stb),
    .nxt_en_n(nxt_en_n), .data_q(tsp_data), .stb_q(tsp_strobe), .en_n_q(tsp_en_n)
  );

  // R9: nothing is launched while idle or in the closing cycle
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || done) |-> (nxt_en_n && !nxt_stb && !nxt_data));

endmodule

// File: tb/tsp_tx_top_tb_top.sv
`timescale 1ns/1ps
module tsp_tx_top_tb_top;
  localparam int DW = 16;
  localparam int EB = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_mode = 1'b0;
  logic [DW-1:0] req_word = '0;
  logic          req_ready, tsp_data, tsp_strobe, tsp_en_n, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tsp_tx_top #(.DATA_W(DW), .EN_BITS(EB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_word(req_word), .tsp_data(tsp_data),
    .tsp_strobe(tsp_strobe), .tsp_en_n(tsp_en_n), .done(done)
  );

  task automatic check(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %b exp %b", req, what, got, exp);
    end
  endtask

  function automatic int closing(logic m);
    return m ? 2 * EB : DW + 1;
  endfunction

  // expected wires at falling edge k, restated from the requirements
  function automatic logic want_en_n(logic m, int k);
    return !(m && k >= 0 && k <= 2 * EB - 1);
  endfunction
  function automatic logic want_stb(logic m, int k);
    return !m && (k == DW);
  endfunction
  function automatic logic want_data(logic m, logic [DW-1:0] w, int k);
    logic [DW-1:0] t;
    if (m) begin
      if (k >= 2 * EB) return 1'b0;
      t = w << (k / 2);
      return t[EB-1];
    end
    if (k >= DW) return 1'b0;
    t = w << k;
    return t[DW-1];
  endfunction

  task automatic transfer(logic m, logic [DW-1:0] w, bit poke);
    int L = closing(m);
    logic [DW-1:0] got_w = '0;
    int guard = 0;
    while (!req_ready && guard < 100) begin
      @(posedge clk); #5; guard++;
    end
    req_valid = 1'b1; req_mode = m; req_word = w;
    @(posedge clk); #5;
    req_valid = 1'b0; req_word = ~w; req_mode = ~m;
    check("R2", "ready after accept", req_ready, 1'b0);
    check("R8", "done at accept", done, 1'b0);
    for (int k = 0; k <= L; k++) begin
      @(negedge clk); #3;
      check(m ? "R5" : "R7", $sformatf("en_n k=%0d", k), tsp_en_n, want_en_n(m, k));
      check(m ? "R7" : "R4", $sformatf("strobe k=%0d", k), tsp_strobe, want_stb(m, k));
      check(m ? "R6" : "R3", $sformatf("data k=%0d", k), tsp_data, want_data(m, w, k));
      if (k == L) check("R9", "data idle at close", tsp_data, 1'b0);
      if (m && (k % 2 == 1) && k < 2 * EB) got_w = {got_w[DW-2:0], tsp_data};
      if (!m && k < DW) got_w = {got_w[DW-2:0], tsp_data};
      if (poke && k == 3) begin
        req_valid = 1'b1; req_word = ~w; req_mode = ~m;
      end
      @(posedge clk); #3;
      if (poke && k == 3) req_valid = 1'b0;
      check("R8", $sformatf("done at rise %0d", k + 1), done, (k + 1 == L));
      check("R2", $sformatf("ready at rise %0d", k + 1), req_ready, (k + 1 > L));
    end
    if (m) check("R6", "slave half-rate word", got_w[EB-1:0] == w[EB-1:0], 1'b1);
    else   check("R3", "slave word", got_w == w, 1'b1);
    if (poke) check("R2", "poked request ignored", got_w[0] == (m ? w[0] : w[0]), 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1));
    repeat (3) @(posedge clk);
    #2;
    check("R1", "en_n in reset", tsp_en_n, 1'b1);
    #3 rst_n = 1'b1;
    @(negedge clk); #3;
    check("R1", "en_n idle", tsp_en_n, 1'b1);
    check("R1", "strobe idle", tsp_strobe, 1'b0);
    check("R1", "data idle", tsp_data, 1'b0);
    check("R1", "ready idle", req_ready, 1'b1);
    check("R1", "done idle", done, 1'b0);
    @(posedge clk); #5;
    // directed corners
    transfer(1'b0, 16'hFFFF, 1'b0);
    transfer(1'b0, 16'h0000, 1'b0);
    transfer(1'b0, 16'hA5C3, 1'b1);
    transfer(1'b1, 16'h007F, 1'b0);
    transfer(1'b1, 16'hFF80, 1'b0);
    transfer(1'b1, 16'h0055, 1'b1);
    transfer(1'b1, 16'h002A, 1'b0);
    // constrained random
    for (int i = 0; i < 40; i++) begin
      logic m = 1'($urandom_range(0, 1));
      logic [DW-1:0] w = DW'($urandom);
      bit p = ($urandom_range(0, 3) == 0);
      transfer(m, w, p);
      if ($urandom_range(0, 1) == 1) begin
        repeat ($urandom_range(1, 4)) @(posedge clk);
        #5;
        @(negedge clk); #3;
        check("R9", "data between jobs", tsp_data, 1'b0);
        check("R7", "en_n between jobs", tsp_en_n, 1'b1);
        @(posedge clk); #5;
      end
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule